// File: doc/BRIEF.md
# Decoupled Instruction Fetch Front End with Lookahead Fill

This block sits between a next-address predictor and an instruction decoder. A fetch engine holds a program counter and looks up one instruction per cycle in a small direct-mapped instruction cache. The predictor supplies the address that follows the one being fetched. Every fetched address gets a slot in an in-order instruction queue. A cache hit fills the slot at once. A miss leaves the slot pending, and the engine moves on to later predicted addresses while the fill is still outstanding. Lines further down the predicted path are therefore requested, and placed in the cache, before the decoder needs them.

A miss tracking table records the lines that are outstanding at the lower level. An address whose line is already outstanding joins that fill and issues no second request. Fill responses write the cache and wake every pending queue slot that waits on the line. The queue releases instructions only from its head, so the decoder sees program order even when fills come back in a different order. A redirect (misprediction flush) empties the queue and reloads the counter. Fills still in flight land in the cache only.

The memory request port is valid/ready. The block raises `mem_req_valid` with a line address. If `mem_req_ready` is low, it keeps the same line and holds valid until the request is taken. A redirect is the only thing that may withdraw the request. The memory answers each accepted request after a fixed number of cycles, with one `mem_rsp_valid` pulse that carries the line address and data. That response has no ready and must always be taken. The decode port is valid/ready too. An instruction leaves the queue only in a cycle where `dec_valid` and `dec_ready` are both high. Each cycle in which the decoder is ready but nothing is valid is a stall: the port shows the NOP word and a stall counter increments.

Top module: `pf_frontend`

## Requirements
- R1: While reset is asserted, `dec_valid` and `mem_req_valid` are 0, `dec_instr` equals the NOP word (default 32'h0000_0013), `stall_count` is 0 and `fetch_pc` equals the reset address (default 32'h0000_1000).
- R2: Instructions reach decode in the exact order produced by starting at the reset address or the last redirect address and repeatedly applying `pred_next_pc`. Addresses are byte addresses aligned to 4. A line holds 4 words and its line address is `pc[31:4]`. Word k of a line is bits [32k+31:32k] of the line data, with k = `pc[3:2]`. `dec_pc` and `dec_instr` carry the address and that word.
- R3: In any cycle with `dec_valid` low, `dec_instr` equals the NOP word. `stall_count` increases by exactly one after each cycle in which `dec_ready` is high and `dec_valid` is low, and is unchanged after every other cycle.
- R4: A miss does not block fetch. While one line request is outstanding, requests for later lines on the predicted path are issued before the first response returns.
- R5: The block never requests a line that is already outstanding.
- R6: At most MSHR_N lines (default 4) are outstanding at once. While that many are outstanding, `mem_req_valid` stays low and fetch does not advance past the new miss.
- R7: While the queue holds Q_DEPTH entries (default 16), `fetch_pc` holds its value and no memory request is raised. After the decoder has been held off long enough for all fills to return, the next Q_DEPTH cycles with `dec_ready` high each deliver a valid instruction.
- R8: In the cycle `redirect_valid` is high, `dec_valid` is low. In the next cycle the queue is empty and `fetch_pc` equals `redirect_pc`. No instruction fetched before the redirect is ever delivered.
- R9: The instruction whose line arrives in a response in cycle t can reach decode in cycle t+1. This holds for a fresh miss, and also for an address that joined a fill already in transit. A joined address therefore waits only for the remaining latency of the original request.
- R10: Once `mem_req_valid` is high with `mem_req_ready` low, the next cycle again has `mem_req_valid` high with the same `mem_req_line`, unless `redirect_valid` is high in that next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| redirect_valid | input | 1 | Flush the queue and reload the fetch counter |
| redirect_pc | input | 32 | New fetch address on redirect |
| fetch_pc | output | 32 | Address currently being fetched, shown to the predictor |
| pred_next_pc | input | 32 | Predicted address that follows `fetch_pc` |
| mem_req_valid | output | 1 | Line fill request valid |
| mem_req_ready | input | 1 | Lower level accepts the request |
| mem_req_line | output | 28 | Requested line address (pc[31:4]) |
| mem_rsp_valid | input | 1 | Fill response valid, always accepted |
| mem_rsp_line | input | 28 | Line address of the response |
| mem_rsp_data | input | 128 | Four instruction words of the line |
| dec_valid | output | 1 | An instruction is offered to decode |
| dec_ready | input | 1 | Decoder takes an instruction this cycle |
| dec_instr | output | 32 | Instruction word, or the NOP word when not valid |
| dec_pc | output | 32 | Address of the offered instruction |
| stall_count | output | 32 | Cycles in which decode was ready but starved |

## Verification
A slot that is never woken leaves the queue head pending for good. The decode port then shows only NOPs, the stall count climbs without bound, and the next address the scoreboard expects never arrives. A table entry that is never freed shows up as fetch stalling at the cap within one fill latency, or as a line being requested a second time. A queue pointer that slips by one shows at the very next handshake as a wrong `dec_pc` or word. The directed cases time the first instruction after a cold redirect and after a joined fill to the exact cycle. A few cycles of extra latency in the wakeup path are therefore caught as well as wrong values.

// File: rtl/pf_pkg.sv
package pf_pkg;
  localparam int unsigned XLEN       = 32;
  localparam int unsigned LINE_WORDS = 4;
  localparam int unsigned LINE_W     = XLEN * LINE_WORDS;
  localparam int unsigned OFF_BITS   = $clog2(LINE_W / 8);
  localparam int unsigned LADDR_W    = XLEN - OFF_BITS;

  typedef logic [XLEN-1:0]    word_t;
  typedef logic [LINE_W-1:0]  line_t;
  typedef logic [LADDR_W-1:0] laddr_t;

  // one queue slot: address, word once known, and whether the word is present
  typedef struct packed {
    word_t pc;
    word_t instr;
    logic  rdy;
  } qent_t;

  typedef enum logic [1:0] {
    FA_IDLE,   // nothing done this cycle
    FA_HIT,    // word available now (cache or passing fill)
    FA_JOIN,   // line already outstanding, wait for it
    FA_MISS    // new line request needed
  } fetch_act_e;

  function automatic laddr_t line_of(input word_t a);
    return a[XLEN-1:OFF_BITS];
  endfunction

  function automatic word_t pick_word(input line_t l, input word_t a);
    return l[a[OFF_BITS-1:2] * XLEN +: XLEN];
  endfunction
endpackage

// File: rtl/pf_icache.sv
module pf_icache
  import pf_pkg::*;
#(
  parameter int unsigned SETS = 8
) (
  input  logic   clk,
  input  logic   rst_n,
  input  laddr_t rd_line,
  output logic   rd_hit,
  output line_t  rd_data,
  input  logic   wr_en,
  input  laddr_t wr_line,
  input  line_t  wr_data
);
  localparam int unsigned IDX_W = $clog2(SETS);
  localparam int unsigned TAG_W = LADDR_W - IDX_W;

  logic [SETS-1:0]  vld_q;
  logic [TAG_W-1:0] tag_q  [SETS];
  line_t            data_q [SETS];

  logic [IDX_W-1:0] rd_idx, wr_idx;
  assign rd_idx = rd_line[IDX_W-1:0];
  assign wr_idx = wr_line[IDX_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     vld_q <= '0;
    else if (wr_en) vld_q[wr_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx]  <= wr_line[LADDR_W-1:IDX_W];
      data_q[wr_idx] <= wr_data;
    end
  end

  assign rd_hit  = vld_q[rd_idx] && (tag_q[rd_idx] == rd_line[LADDR_W-1:IDX_W]);
  assign rd_data = data_q[rd_idx];
endmodule

// File: rtl/pf_mshr.sv
module pf_mshr
  import pf_pkg::*;
#(
  parameter int unsigned N = 4
) (
  input  logic   clk,
  input  logic   rst_n,
  input  laddr_t lk_line,
  output logic   lk_hit,
  output logic   full,
  input  logic   alloc_en,
  input  laddr_t alloc_line,
  input  logic   free_en,
  input  laddr_t free_line
);
  logic [N-1:0] vld_q;
  laddr_t       line_q [N];
  logic [N-1:0] lk_match, fr_match, slot_oh;

  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign lk_match[i] = vld_q[i] && (line_q[i] == lk_line);
    assign fr_match[i] = vld_q[i] && (line_q[i] == free_line);
  end

  // lowest free slot
  always_comb begin
    slot_oh = '0;
    for (int i = 0; i < N; i++) begin
      if (!vld_q[i] && (slot_oh == '0)) slot_oh[i] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        if (free_en && fr_match[i])      vld_q[i] <= 1'b0;
        else if (alloc_en && slot_oh[i]) vld_q[i] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < N; i++) begin
      if (alloc_en && slot_oh[i]) line_q[i] <= alloc_line;
    end
  end

  assign lk_hit = |lk_match;
  assign full   = &vld_q;
endmodule

// File: rtl/pf_iqueue.sv
module pf_iqueue
  import pf_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   flush,
  input  logic   push_en,
  input  qent_t  push_ent,
  input  logic   pop_en,
  input  logic   wake_en,
  input  laddr_t wake_line,
  input  line_t  wake_data,
  output qent_t  head,
  output logic   head_ok,
  output logic   full
);
  localparam int unsigned PTR_W = $clog2(DEPTH);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  qent_t            slot_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;
  logic             do_push, do_pop;

  assign do_push = push_en && !flush;
  assign do_pop  = pop_en && !flush;

  // slot storage: a push claims the tail slot, a fill completes waiting slots
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (do_push && (wr_ptr == PTR_W'(i))) begin
          slot_q[i] <= push_ent;
        end else if (wake_en && !slot_q[i].rdy &&
                     (line_of(slot_q[i].pc) == wake_line)) begin
          slot_q[i].instr <= pick_word(wake_data, slot_q[i].pc);
          slot_q[i].rdy   <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
      if (do_push && !do_pop)      count <= count + 1'b1;
      else if (!do_push && do_pop) count <= count - 1'b1;
    end
  end

  assign head    = slot_q[rd_ptr];
  assign head_ok = (count != '0) && head.rdy;
  assign full    = (count == CNT_W'(DEPTH));
endmodule

// File: rtl/pf_frontend.sv
module pf_frontend
  import pf_pkg::*;
#(
  parameter int unsigned Q_DEPTH    = 16,
  parameter int unsigned MSHR_N     = 4,
  parameter int unsigned CACHE_SETS = 8,
  parameter int unsigned STALL_W    = 32,
  parameter logic [31:0] RESET_PC   = 32'h0000_1000,
  parameter logic [31:0] NOP_WORD   = 32'h0000_0013
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                redirect_valid,
  input  logic [31:0]         redirect_pc,
  output logic [31:0]         fetch_pc,
  input  logic [31:0]         pred_next_pc,
  output logic                mem_req_valid,
  input  logic                mem_req_ready,
  output logic [27:0]         mem_req_line,
  input  logic                mem_rsp_valid,
  input  logic [27:0]         mem_rsp_line,
  input  logic [127:0]        mem_rsp_data,
  output logic                dec_valid,
  input  logic                dec_ready,
  output logic [31:0]         dec_instr,
  output logic [31:0]         dec_pc,
  output logic [STALL_W-1:0]  stall_count
);
  word_t      pc_q;
  laddr_t     cur_line;
  logic       c_hit, m_hit, m_full, q_full, q_head_ok;
  line_t      c_data;
  logic       byp, fetch_ok, push, alloc, pop;
  fetch_act_e act;
  qent_t      push_ent, q_head;

  assign cur_line = line_of(pc_q);
  assign byp      = mem_rsp_valid && (mem_rsp_line == cur_line);
  assign fetch_ok = rst_n && !redirect_valid && !q_full;

  // lookup outcome for the current address
  always_comb begin
    act = FA_IDLE;
    if (fetch_ok) begin
      if (c_hit || byp) act = FA_HIT;
      else if (m_hit)   act = FA_JOIN;
      else if (!m_full) act = FA_MISS;
    end
  end

  assign mem_req_valid = (act == FA_MISS);
  assign mem_req_line  = cur_line;
  assign alloc         = mem_req_valid && mem_req_ready;
  assign push          = (act == FA_HIT) || (act == FA_JOIN) || alloc;

  always_comb begin
    push_ent.pc    = pc_q;
    push_ent.rdy   = (act == FA_HIT);
    push_ent.instr = (act == FA_HIT) ? pick_word(byp ? mem_rsp_data : c_data, pc_q) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              pc_q <= RESET_PC;
    else if (redirect_valid) pc_q <= redirect_pc;
    else if (push)           pc_q <= pred_next_pc;
  end
  assign fetch_pc = pc_q;

  pf_icache #(.SETS(CACHE_SETS)) cache_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_line (cur_line),
    .rd_hit  (c_hit),
    .rd_data (c_data),
    .wr_en   (mem_rsp_valid),
    .wr_line (mem_rsp_line),
    .wr_data (mem_rsp_data)
  );

  pf_mshr #(.N(MSHR_N)) mshr_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .lk_line    (cur_line),
    .lk_hit     (m_hit),
    .full       (m_full),
    .alloc_en   (alloc),
    .alloc_line (cur_line),
    .free_en    (mem_rsp_valid),
    .free_line  (mem_rsp_line)
  );

  pf_iqueue #(.DEPTH(Q_DEPTH)) queue_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (redirect_valid),
    .push_en   (push),
    .push_ent  (push_ent),
    .pop_en    (pop),
    .wake_en   (mem_rsp_valid),
    .wake_line (mem_rsp_line),
    .wake_data (mem_rsp_data),
    .head      (q_head),
    .head_ok   (q_head_ok),
    .full      (q_full)
  );

  // decode side
  assign dec_valid = q_head_ok && !redirect_valid;
  assign dec_instr = dec_valid ? q_head.instr : NOP_WORD;
  assign dec_pc    = q_head.pc;
  assign pop       = dec_valid && dec_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       stall_count <= '0;
    else if (dec_ready && !dec_valid) stall_count <= stall_count + 1'b1;
  end
endmodule

// File: rtl/pf_frontend_chk.sv
module pf_frontend_chk #(
  parameter int unsigned STALL_W  = 32,
  parameter logic [31:0] NOP_WORD = 32'h0000_0013
) (
  input logic               clk,
  input logic               rst_n,
  input logic               redirect_valid,
  input logic [31:0]        fetch_pc,
  input logic               mem_req_valid,
  input logic               mem_req_ready,
  input logic [27:0]        mem_req_line,
  input logic               dec_valid,
  input logic               dec_ready,
  input logic [31:0]        dec_instr,
  input logic [STALL_W-1:0] stall_count,
  input logic               q_full,
  input logic               m_full
);
  // R3
  nop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |-> dec_instr == NOP_WORD);

  // R3
  stall_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_ready && !dec_valid) |=> stall_count == $past(stall_count) + STALL_W'(1));

  // R3
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dec_ready || dec_valid) |=> $stable(stall_count));

  // R6
  mshr_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_full |-> !mem_req_valid);

  // R7
  qfull_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q_full && !redirect_valid) |=> $stable(fetch_pc));

  // R7
  qfull_noreq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_full |-> !mem_req_valid);

  // R8
  redirect_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |=> !dec_valid);

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (redirect_valid || (mem_req_valid && $stable(mem_req_line))));
endmodule

bind pf_frontend pf_frontend_chk #(.STALL_W(STALL_W), .NOP_WORD(NOP_WORD)) chk_i (
  .clk            (clk),
  .rst_n          (rst_n),
  .redirect_valid (redirect_valid),
  .fetch_pc       (fetch_pc),
  .mem_req_valid  (mem_req_valid),
  .mem_req_ready  (mem_req_ready),
  .mem_req_line   (mem_req_line),
  .dec_valid      (dec_valid),
  .dec_ready      (dec_ready),
  .dec_instr      (dec_instr),
  .stall_count    (stall_count),
  .q_full         (q_full),
  .m_full         (m_full)
);

// File: tb/pf_frontend_tb_top.sv
`timescale 1ns/1ps
module pf_frontend_tb_top;
  localparam int          DEPTH  = 16;
  localparam int          MSHRS  = 4;
  localparam int          LAT    = 10;
  localparam logic [31:0] RST_PC = 32'h0000_1000;
  localparam logic [31:0] NOP    = 32'h0000_0013;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         redirect_valid;
  logic [31:0]  redirect_pc;
  logic [31:0]  fetch_pc;
  logic [31:0]  pred_next_pc;
  logic         mem_req_valid;
  logic         mem_req_ready;
  logic [27:0]  mem_req_line;
  logic         mem_rsp_valid;
  logic [27:0]  mem_rsp_line;
  logic [127:0] mem_rsp_data;
  logic         dec_valid;
  logic         dec_ready;
  logic [31:0]  dec_instr;
  logic [31:0]  dec_pc;
  logic [31:0]  stall_count;

  always #2 clk = ~clk;

  pf_frontend #(.Q_DEPTH(DEPTH), .MSHR_N(MSHRS), .RESET_PC(RST_PC), .NOP_WORD(NOP)) dut_i (
    .clk(clk), .rst_n(rst_n), .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
    .fetch_pc(fetch_pc), .pred_next_pc(pred_next_pc),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_line(mem_req_line),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_line(mem_rsp_line), .mem_rsp_data(mem_rsp_data),
    .dec_valid(dec_valid), .dec_ready(dec_ready), .dec_instr(dec_instr), .dec_pc(dec_pc),
    .stall_count(stall_count)
  );

  int checks = 0;
  int fails  = 0;
  int mode   = 0;

  // ---------------- reference functions ----------------
  function automatic logic [31:0] pred_fn(input logic [31:0] pc, input int m);
    if (m == 1)            return pc + 32'h10;
    if (pc[6:2] == 5'd19)  return pc - 32'h40;
    return pc + 32'h4;
  endfunction

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return a ^ {a[15:0], a[31:16]} ^ 32'h5A5A_0F0F;
  endfunction

  function automatic logic [127:0] mem_line(input logic [27:0] l);
    logic [127:0] d;
    for (int k = 0; k < 4; k++) d[32*k +: 32] = mem_word({l, 4'b0} + 32'(4 * k));
    return d;
  endfunction

  always_comb pred_next_pc = pred_fn(fetch_pc, mode);

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // ---------------- drive plan and bench state ----------------
  logic        drv_redir = 0;
  logic [31:0] drv_redir_pc = '0;
  int          drv_mode = 0;
  logic        drv_dec_rdy = 0;
  logic        drv_mem_rdy = 1;

  int          cyc = 0;
  logic [31:0] exp_pc = RST_PC;
  logic [31:0] exp_stall = '0;
  logic [27:0] fq_line [32];
  int          fq_due  [32];
  int          fq_rd = 0, fq_wr = 0, fq_n = 0;
  int          outstanding = 0;
  int          max_out = 0;
  bit          prev_pend = 0;
  logic [27:0] prev_line = '0;
  logic [27:0] watch_line = '1;
  int          watch_cyc = -1;
  int          watch_cnt = 0;
  bit          s_valid, s_req;
  logic [27:0] s_req_line;
  logic [31:0] s_pc;

  task automatic step();
    bit rsp_now, redir_now;
    @(negedge clk);
    cyc++;
    rst_n          = 1'b1;
    rsp_now        = 0;
    mem_rsp_valid  = 1'b0;
    if (fq_n > 0 && fq_due[fq_rd] == cyc) begin
      mem_rsp_valid = 1'b1;
      mem_rsp_line  = fq_line[fq_rd];
      mem_rsp_data  = mem_line(fq_line[fq_rd]);
      fq_rd = (fq_rd + 1) % 32;
      fq_n--;
      rsp_now = 1;
    end
    redir_now      = drv_redir;
    redirect_valid = drv_redir;
    redirect_pc    = drv_redir_pc;
    if (drv_redir) mode = drv_mode;
    drv_redir      = 0;
    dec_ready      = drv_dec_rdy;
    mem_req_ready  = drv_mem_rdy;
    #1;
    s_valid    = dec_valid;
    s_req      = mem_req_valid && mem_req_ready;
    s_req_line = mem_req_line;
    s_pc       = fetch_pc;
    // R3: idle port shows NOP, stall count tracks starved cycles
    if (!dec_valid) chk(dec_instr == NOP, "R3", "nop word", dec_instr, NOP);
    chk(stall_count == exp_stall, "R3", "stall count", stall_count, exp_stall);
    // R8: no delivery in the redirect cycle
    if (redir_now) chk(!dec_valid, "R8", "valid in redirect cycle", 32'(dec_valid), 0);
    // R2: in-order predicted stream
    if (dec_valid && dec_ready) begin
      chk(dec_pc == exp_pc, "R2", "dec_pc", dec_pc, exp_pc);
      chk(dec_instr == mem_word(exp_pc), "R2", "dec_instr", dec_instr, mem_word(exp_pc));
    end
    // R10: pending request holds
    if (prev_pend && !redir_now) begin
      chk(mem_req_valid, "R10", "request withdrawn", 32'(mem_req_valid), 1);
      chk(mem_req_line == prev_line, "R10", "request line changed",
          32'(mem_req_line), 32'(prev_line));
    end
    // R6: cap on outstanding lines
    chk(outstanding <= MSHRS, "R6", "outstanding lines", outstanding, MSHRS);
    if (outstanding == MSHRS)
      chk(!mem_req_valid, "R6", "request while table full", 32'(mem_req_valid), 0);
    // R5: no duplicate request of an in-flight line
    if (s_req) begin
      bit dup = 0;
      for (int k = 0; k < fq_n; k++) if (fq_line[(fq_rd + k) % 32] == mem_req_line) dup = 1;
      chk(!dup, "R5", "duplicate line request", 32'(mem_req_line), 0);
      if (mem_req_line == watch_line) begin
        watch_cnt++;
        watch_cyc = cyc;
      end
    end
    // bookkeeping after checks
    if (rsp_now) outstanding--;
    if (s_req) begin
      fq_line[fq_wr] = mem_req_line;
      fq_due[fq_wr]  = cyc + LAT;
      fq_wr = (fq_wr + 1) % 32;
      fq_n++;
      outstanding++;
    end
    if (outstanding > max_out) max_out = outstanding;
    if (dec_ready && !dec_valid) exp_stall = exp_stall + 1;
    if (dec_valid && dec_ready) exp_pc = pred_fn(exp_pc, mode);
    if (redir_now) exp_pc = redirect_pc;
    prev_pend = mem_req_valid && !mem_req_ready;
    prev_line = mem_req_line;
  endtask

  task automatic redirect_to(input logic [31:0] pc, input int m);
    drv_redir    = 1;
    drv_redir_pc = pc;
    drv_mode     = m;
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual expired expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  // ---------------- main sequence ----------------
  initial begin
    int c0, first_v, r1;
    logic [31:0] held_pc;
    int bad;
    void'($urandom(32'd4242));
    rst_n = 1'b0; redirect_valid = 0; redirect_pc = '0; dec_ready = 0;
    mem_req_ready = 1; mem_rsp_valid = 0; mem_rsp_line = '0; mem_rsp_data = '0;
    repeat (5) @(negedge clk);
    #1;
    // R1 reset state
    chk(!dec_valid, "R1", "dec_valid", 32'(dec_valid), 0);
    chk(!mem_req_valid, "R1", "mem_req_valid", 32'(mem_req_valid), 0);
    chk(dec_instr == NOP, "R1", "dec_instr", dec_instr, NOP);
    chk(stall_count == 0, "R1", "stall_count", stall_count, 0);
    chk(fetch_pc == RST_PC, "R1", "fetch_pc", fetch_pc, RST_PC);

    // R4 and R9 (fresh miss): cold start
    drv_dec_rdy = 1; drv_mem_rdy = 1;
    c0 = -1; first_v = -1;
    begin
      bit second_seen = 0;
      logic [27:0] l0 = '0;
      for (int i = 0; i < 40; i++) begin
        step();
        if (s_req && c0 < 0) begin c0 = cyc; l0 = s_req_line; end
        else if (s_req && c0 >= 0 && s_req_line != l0 && cyc < c0 + LAT) second_seen = 1;
        if (s_valid && first_v < 0) first_v = cyc;
      end
      chk(second_seen, "R4", "later line requested before first fill", 32'(second_seen), 1);
      chk(first_v == c0 + LAT + 1, "R9", "fresh miss delivery cycle", first_v, c0 + LAT + 1);
    end

    // R7 queue full holds fetch
    drv_dec_rdy = 0;
    bad = 0;
    held_pc = '0;
    for (int i = 0; i < 120; i++) begin
      step();
      if (i == 79) held_pc = s_pc;
      if (i >= 80 && (s_pc != held_pc || mem_req_valid)) bad++;
    end
    chk(bad == 0, "R7", "fetch moved or requested while full", bad, 0);
    drv_dec_rdy = 1;
    for (int i = 0; i < DEPTH; i++) begin
      step();
      chk(s_valid, "R7", "full queue drains back to back", 32'(s_valid), 1);
    end

    // R6 table cap with a new line every address
    redirect_to(32'h0000_3000, 1);
    max_out = 0;
    for (int i = 0; i < 30; i++) step();
    chk(max_out == MSHRS, "R6", "peak outstanding", max_out, MSHRS);

    // R9 joined fill: quiet the table first
    drv_mem_rdy = 0;
    redirect_to(32'h0000_5000, 0);
    for (int i = 0; i < 20; i++) step();
    drv_mem_rdy = 1;
    watch_line = 28'h0000_800;
    watch_cnt = 0;
    redirect_to(32'h0000_8000, 0);
    step();
    r1 = cyc;
    for (int i = 0; i < 3; i++) step();
    redirect_to(32'h0000_8008, 0);
    step();
    first_v = -1;
    for (int i = 0; i < 40; i++) begin
      step();
      if (s_valid && first_v < 0) first_v = cyc;
    end
    chk(watch_cyc == r1 + 1, "R9", "original request cycle", watch_cyc, r1 + 1);
    chk(first_v == watch_cyc + LAT + 1, "R9", "joined delivery cycle", first_v, watch_cyc + LAT + 1);
    chk(watch_cnt == 1, "R5", "requests of joined line", watch_cnt, 1);

    // random traffic
    for (int i = 0; i < 8000; i++) begin
      drv_dec_rdy = ($urandom % 4) != 0;
      drv_mem_rdy = ($urandom % 5) != 0;
      if (($urandom % 100) == 0)
        redirect_to(32'h0000_1000 + (($urandom % 1024) * 4), (($urandom % 5) == 0) ? 1 : 0);
      step();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule